// File: doc/BRIEF.md
# JTAG-to-SPI Flash Bridge

This block lets a JTAG host reach an external SPI flash through a user data register, so that no test-pin access to the flash is needed. It sits behind the boundary-scan user-instruction port, which supplies a select line, the capture, shift and update strobes, the test clock and the serial data lines. Everything runs in the test-clock domain. The SPI serial clock is made in fabric logic from the test clock, not from a dedicated configuration clock pin.

One DR scan carries exactly one SPI transaction, framed by chip select. The host first shifts any number of zeros and then a single 1 bit that marks the start. A bit count follows, MSB first. It gives the total number of SPI clocks, transmit and receive bits together. Next come that many payload bits, which the bridge places on MOSI in arrival order, so bytes sent MSB first reach the flash MSB first. The bit sampled from MISO for each SPI clock returns on TDO a fixed number of test-clock cycles later. The host therefore shifts that many extra bits at the end and drops the same number of leading TDO bits from the receive window. The capture or update strobe, a test-logic reset, or losing the instruction select all end the transaction at once and return the bridge to its marker search.

Top module: `jtag_spi_bridge`

## Requirements
- R1: While `tap_reset` is high, `spi_cs_n` is 1, `spi_sck` is 0 and `tdo` is 0.
- R2: With `user1_sel` low, shifting any bit pattern never drives `spi_cs_n` low and never produces an SPI clock edge.
- R3: In the marker search, 0 bits on `tdi` are ignored. The first 1 bit is the marker. The next CNT_W bits form the bit count, MSB first. A scan made only of zeros never asserts chip select.
- R4: A scan with count N > 0 produces exactly N rising edges of `spi_sck`, all while `spi_cs_n` is low. Chip select goes low at the last count bit and goes high again after the N-th clock. Further shifted bits in the same scan start nothing.
- R5: Payload bit k (k = 0 for the first bit after the count) is on `spi_mosi` at the k-th rising edge of `spi_sck`. Bytes shifted MSB first therefore leave MSB first.
- R6: Payload bit k is shifted in at test-clock rising edge E. The `tdo` value that the host captures at rising edge E + SKIP_BITS equals the `spi_miso` level sampled at the k-th `spi_sck` rising edge. At every other capture in the scan, `tdo` is 0.
- R7: `spi_sck` is low whenever `spi_cs_n` is high. It is high only during the low half of a test-clock cycle that follows a shifted payload bit.
- R8: A capture or update strobe during a transaction deasserts `spi_cs_n` at that edge. It stops further SPI clocks and restarts the marker search, so the next scan runs as a fresh transaction.
- R9: A count of zero ends the scan without asserting chip select.
- R10: Sending opcode 0x9F followed by 24 receive clocks returns the flash identification bytes on `tdo`. The first byte returned is the manufacturer code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all bridge state advances on it |
| tap_reset | input | 1 | Test-logic reset, active high, asynchronous |
| user1_sel | input | 1 | High while the user-1 instruction is selected |
| dr_capture | input | 1 | Capture-DR strobe |
| dr_shift | input | 1 | Shift-DR strobe |
| dr_update | input | 1 | Update-DR strobe |
| tdi | input | 1 | Scan data from the host |
| tdo | output | 1 | Scan data to the host (delayed MISO) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI serial clock, idles low |
| spi_mosi | output | 1 | Data to the flash |
| spi_miso | input | 1 | Data from the flash |

## Verification
Every cycle, the assertions check the header state machine. Zeros before the marker keep the search going, a shifted payload bit takes exactly one off the remaining count, a finished transaction stays finished for the rest of the scan, and a strobe or a dropped select clears the bridge and raises chip select. Only the bench scenarios, run against a flash model, can show the end-to-end properties. These are the exact number of SPI clocks per scan, bit order on MOSI, alignment of returned data after the skip gap, correct counts across many lengths and leading-zero runs, and the identification read.

// File: rtl/jsb_pkg.sv
package jsb_pkg;

   // Progress of one DR scan through its frame.
   typedef enum logic [1:0] {
      PH_SEEK = 2'd0,   // waiting for the start marker
      PH_HDR  = 2'd1,   // collecting the bit count
      PH_XFER = 2'd2,   // SPI clocks outstanding
      PH_DONE = 2'd3    // transaction finished, rest of scan ignored
   } jsb_phase_e;

endpackage

// File: rtl/jsb_frame_ctrl.sv
module jsb_frame_ctrl
   import jsb_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic       tck,
   input  logic       trst,
   input  logic       sel,
   input  logic       capture,
   input  logic       update,
   input  logic       shift,
   input  logic       tdi,
   output jsb_phase_e phase_o,
   output logic       launch_o
);

   localparam int IDX_W = (CNT_W > 1) ? $clog2(CNT_W) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CNT_W - 1);

   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("jsb_frame_ctrl: CNT_W must be at least 2");
   end

   jsb_phase_e       phase_q;
   logic [CNT_W-1:0] len_q;
   logic [IDX_W-1:0] idx_q;
   logic             abort;
   logic             adv;
   logic [CNT_W-1:0] len_next_hdr;

   // Any strobe or loss of the instruction select ends the frame.
   assign abort        = capture | update | ~sel;
   assign adv          = sel & shift & ~capture & ~update;
   assign len_next_hdr = {len_q[CNT_W-2:0], tdi};

   always_ff @(posedge tck or posedge trst) begin
      if (trst) begin
         phase_q <= PH_SEEK;
         len_q   <= '0;
         idx_q   <= '0;
      end else if (abort) begin
         phase_q <= PH_SEEK;
         len_q   <= '0;
         idx_q   <= '0;
      end else if (adv) begin
         unique case (phase_q)
            PH_SEEK: begin
               if (tdi) begin
                  phase_q <= PH_HDR;
                  len_q   <= '0;
                  idx_q   <= '0;
               end
            end
            PH_HDR: begin
               len_q <= len_next_hdr;
               if (idx_q == IDX_LAST) begin
                  phase_q <= (len_next_hdr != '0) ? PH_XFER : PH_DONE;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            PH_XFER: begin
               len_q <= len_q - 1'b1;
               if (len_q == CNT_W'(1)) phase_q <= PH_DONE;
            end
            default: ;
         endcase
      end
   end

   assign phase_o  = phase_q;
   assign launch_o = adv & (phase_q == PH_XFER);

   AST_SEEK_SKIPS_ZEROS: assert property (@(posedge tck) disable iff (trst)
      (phase_q == PH_SEEK && adv && !tdi) |=> (phase_q == PH_SEEK)); // R3

   AST_ONE_BIT_PER_SHIFT: assert property (@(posedge tck) disable iff (trst)
      (phase_q == PH_XFER && adv) |=> (len_q == $past(len_q) - 1'b1)); // R4

   AST_DONE_IS_FINAL: assert property (@(posedge tck) disable iff (trst)
      (phase_q == PH_DONE && !abort) |=> (phase_q == PH_DONE)); // R4

   AST_STROBE_CLEARS: assert property (@(posedge tck) disable iff (trst)
      (capture || update) |=> (phase_q == PH_SEEK && len_q == '0)); // R8

endmodule

// File: rtl/jsb_spi_drive.sv
module jsb_spi_drive
   import jsb_pkg::*;
(
   input  logic       tck,
   input  logic       trst,
   input  jsb_phase_e phase,
   input  logic       launch,
   input  logic       tdi,
   output logic       sck_en_o,
   output logic       spi_cs_n,
   output logic       spi_sck,
   output logic       spi_mosi
);

   logic sck_en_q;
   logic mosi_q;

   // A launched bit is held on MOSI for the whole next cycle; the clock
   // pulse occupies the low half of that cycle.
   always_ff @(posedge tck or posedge trst) begin
      if (trst) begin
         sck_en_q <= 1'b0;
         mosi_q   <= 1'b0;
      end else begin
         sck_en_q <= launch;
         if (launch) mosi_q <= tdi;
      end
   end

   assign sck_en_o = sck_en_q;
   assign spi_cs_n = ~((phase == PH_XFER) | sck_en_q);
   assign spi_sck  = sck_en_q & ~tck;
   assign spi_mosi = mosi_q;

endmodule

// File: rtl/jsb_miso_return.sv
module jsb_miso_return #(
   parameter int SKIP_BITS = 1
) (
   input  logic tck,
   input  logic trst,
   input  logic sck_en,
   input  logic spi_miso,
   output logic tdo
);

   if (SKIP_BITS < 1) begin : g_bad_skip
      $error("jsb_miso_return: SKIP_BITS must be at least 1");
   end

   logic sample_q;

   // MISO is taken as SCK rises, which is the falling edge of the test
   // clock; outside SPI clocks the return path carries zeros.
   always_ff @(negedge tck or posedge trst) begin
      if (trst) sample_q <= 1'b0;
      else      sample_q <= sck_en ? spi_miso : 1'b0;
   end

   if (SKIP_BITS == 1) begin : g_direct
      assign tdo = sample_q;
   end else begin : g_delay
      logic [SKIP_BITS-2:0] dly_q;
      always_ff @(negedge tck or posedge trst) begin
         if (trst) dly_q <= '0;
         else      dly_q <= {dly_q, sample_q};
      end
      assign tdo = dly_q[SKIP_BITS-2];
   end

endmodule

// File: rtl/jtag_spi_bridge.sv
module jtag_spi_bridge
   import jsb_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int SKIP_BITS = 1
) (
   input  logic tck,
   input  logic tap_reset,
   input  logic user1_sel,
   input  logic dr_capture,
   input  logic dr_shift,
   input  logic dr_update,
   input  logic tdi,
   output logic tdo,
   output logic spi_cs_n,
   output logic spi_sck,
   output logic spi_mosi,
   input  logic spi_miso
);

   jsb_phase_e phase;
   logic       launch;
   logic       sck_en;

   jsb_frame_ctrl #(.CNT_W(CNT_W)) u_frame (
      .tck      (tck),
      .trst     (tap_reset),
      .sel      (user1_sel),
      .capture  (dr_capture),
      .update   (dr_update),
      .shift    (dr_shift),
      .tdi      (tdi),
      .phase_o  (phase),
      .launch_o (launch)
   );

   jsb_spi_drive u_drive (
      .tck      (tck),
      .trst     (tap_reset),
      .phase    (phase),
      .launch   (launch),
      .tdi      (tdi),
      .sck_en_o (sck_en),
      .spi_cs_n (spi_cs_n),
      .spi_sck  (spi_sck),
      .spi_mosi (spi_mosi)
   );

   jsb_miso_return #(.SKIP_BITS(SKIP_BITS)) u_return (
      .tck      (tck),
      .trst     (tap_reset),
      .sck_en   (sck_en),
      .spi_miso (spi_miso),
      .tdo      (tdo)
   );

   AST_CS_NEEDS_SEL: assert property (@(posedge tck) disable iff (tap_reset)
      !user1_sel |=> spi_cs_n); // R2

   AST_STROBE_RAISES_CS: assert property (@(posedge tck) disable iff (tap_reset)
      (dr_capture || dr_update) |=> spi_cs_n); // R8

endmodule

// File: tb/tb_jtag_spi_bridge.sv
module tb_jtag_spi_bridge;

   localparam int TCK_P = 20;
   localparam int CNT_W = 32;
   localparam int SKIP  = 1;
   localparam logic [23:0] FLASH_ID = 24'h20BA19;

   logic tck = 1'b0;
   logic tap_reset, user1_sel, dr_capture, dr_shift, dr_update, tdi;
   logic tdo, spi_cs_n, spi_sck, spi_mosi;
   logic miso_r;

   jtag_spi_bridge #(.CNT_W(CNT_W), .SKIP_BITS(SKIP)) dut (
      .tck(tck), .tap_reset(tap_reset), .user1_sel(user1_sel),
      .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
      .tdi(tdi), .tdo(tdo), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(miso_r)
   );

   always #(TCK_P/2) tck = ~tck;

   int  n_chk = 0, n_fail = 0;
   bit  fin = 0;
   int  pc = 0, sck_cnt = 0, stray = 0, cs_fall = 0, fi = 0;
   logic ml [0:511];
   logic pl [0:511];
   logic ts [0:1023];

   // Flash model: identification after 0x9F, otherwise echo of the
   // previous MOSI bit.
   function automatic logic resp(int k, logic [7:0] opc, logic prev);
      if (k >= 8 && k < 32 && opc == 8'h9F) return FLASH_ID[31-k];
      if (k >= 1) return prev;
      return 1'b0;
   endfunction

   always @(negedge spi_cs_n) begin
      pc = 0; miso_r = 1'b0; cs_fall++;
   end
   always @(posedge spi_sck) begin
      if (!spi_cs_n) begin
         if (pc < 512) ml[pc] = spi_mosi;
         pc++; sck_cnt++;
      end else stray++;
   end
   always @(negedge spi_sck) begin
      if (!spi_cs_n && pc >= 1 && pc < 512)
         miso_r = resp(pc, {ml[0],ml[1],ml[2],ml[3],ml[4],ml[5],ml[6],ml[7]}, ml[pc-1]);
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input logic b, input logic s);
      tdi = b; user1_sel = s; dr_shift = 1'b1;
      @(negedge tck); #(TCK_P/4);
      if (fi < 1024) ts[fi] = tdo;
      fi++;
      @(posedge tck); #1;
   endtask

   task automatic strobe(input logic cap, input logic upd, input logic s);
      dr_shift = 1'b0; dr_capture = cap; dr_update = upd; user1_sel = s;
      @(posedge tck); #1;
      dr_capture = 1'b0; dr_update = 1'b0;
   endtask

   task automatic run_scan(input int n, input int z, input int pad, input logic s);
      logic [31:0] cnt;
      cnt = n;
      sck_cnt = 0; cs_fall = 0; fi = 0;
      strobe(1'b1, 1'b0, s);
      for (int i = 0; i < z; i++) step(1'b0, s);
      step(1'b1, s);
      for (int b = 31; b >= 0; b--) step(cnt[b], s);
      for (int k = 0; k < n; k++) step(pl[k], s);
      for (int p = 0; p < pad; p++) step(1'b1, s);
      strobe(1'b0, 1'b1, s);
   endtask

   function automatic logic exp_miso(int k);
      logic [7:0] opc;
      opc = {pl[0],pl[1],pl[2],pl[3],pl[4],pl[5],pl[6],pl[7]};
      return resp(k, opc, (k >= 1) ? pl[k-1] : 1'b0);
   endfunction

   task automatic check_scan(input int n, input int z);
      int bad_mosi, bad_tdo, p0;
      bad_mosi = 0; bad_tdo = 0;
      p0 = z + 1 + CNT_W;
      chk(sck_cnt == n, "R4 sck count", sck_cnt, n);
      for (int k = 0; k < n; k++) if (ml[k] !== pl[k]) bad_mosi++;
      chk(bad_mosi == 0, "R5 mosi order mismatches", bad_mosi, 0);
      for (int i = 0; i < fi; i++) begin
         logic e;
         e = (i >= p0 + SKIP && i < p0 + SKIP + n) ? exp_miso(i - p0 - SKIP) : 1'b0;
         if (ts[i] !== e) bad_tdo++;
      end
      chk(bad_tdo == 0, "R6 tdo mismatches", bad_tdo, 0);
      chk(spi_cs_n === 1'b1, "R4 cs released", spi_cs_n, 1);
   endtask

   initial begin
      #(TCK_P * 150000);
      if (!fin) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      int aborted;
      tap_reset = 1'b1; user1_sel = 1'b0; dr_capture = 1'b0;
      dr_shift = 1'b0; dr_update = 1'b0; tdi = 1'b0; miso_r = 1'b0;
      repeat (3) @(posedge tck);
      #(TCK_P/4);
      chk(spi_cs_n === 1'b1, "R1 cs idle", spi_cs_n, 1);
      chk(spi_sck === 1'b0, "R1 sck idle", spi_sck, 0);
      chk(tdo === 1'b0, "R1 tdo idle", tdo, 0);
      @(posedge tck); #1;
      tap_reset = 1'b0;

      // R4 R5 R6: sweep over lengths, leading-zero runs and trailing pads
      lfsr = 16'hACE1;
      for (int n = 1; n <= 41; n++) begin
         int len;
         len = (n == 41) ? 300 : n;
         for (int k = 0; k < len; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pl[k] = lfsr[0];
         end
         run_scan(len, n % 4, SKIP + (n % 3), 1'b1);
         check_scan(len, n % 4);
      end

      // R10: identification read
      for (int k = 0; k < 32; k++) pl[k] = (k < 8) ? (8'h9F >> (7 - k)) & 1 : 1'b0;
      run_scan(32, 2, SKIP, 1'b1);
      check_scan(32, 2);
      begin
         logic [23:0] got;
         for (int j = 0; j < 24; j++) got[23-j] = ts[2 + 1 + CNT_W + 8 + j + SKIP];
         chk(got[23:16] == 8'h20, "R10 manufacturer byte", got[23:16], 8'h20);
         chk(got == FLASH_ID, "R10 full id", got, FLASH_ID);
      end

      // R2: other instruction selected
      run_scan(16, 0, SKIP, 1'b0);
      chk(cs_fall == 0, "R2 cs never low", cs_fall, 0);
      chk(sck_cnt == 0, "R2 no sck", sck_cnt, 0);

      // R9: zero count
      run_scan(0, 1, 4, 1'b1);
      chk(cs_fall == 0, "R9 zero count cs", cs_fall, 0);
      chk(sck_cnt == 0, "R9 zero count sck", sck_cnt, 0);

      // R3: scan of zeros only
      sck_cnt = 0; cs_fall = 0; fi = 0;
      strobe(1'b1, 1'b0, 1'b1);
      for (int i = 0; i < 60; i++) step(1'b0, 1'b1);
      strobe(1'b0, 1'b1, 1'b1);
      chk(cs_fall == 0, "R3 no marker no cs", cs_fall, 0);

      // R8: abort by capture strobe mid-transaction
      sck_cnt = 0; cs_fall = 0; fi = 0;
      strobe(1'b1, 1'b0, 1'b1);
      step(1'b1, 1'b1);
      for (int b = 31; b >= 0; b--) step(((32'd20 >> b) & 1) != 0, 1'b1);
      for (int k = 0; k < 5; k++) step(1'b1, 1'b1);
      strobe(1'b1, 1'b0, 1'b1);
      aborted = sck_cnt;
      chk(spi_cs_n === 1'b1, "R8 cs after abort", spi_cs_n, 1);
      chk(aborted == 5, "R8 clocks before abort", aborted, 5);
      repeat (4) step(1'b0, 1'b1);
      chk(sck_cnt == 5, "R8 no clocks after abort", sck_cnt, 5);
      for (int k = 0; k < 12; k++) pl[k] = k[0];
      run_scan(12, 3, SKIP, 1'b1);
      check_scan(12, 3);

      chk(stray == 0, "R7 sck with cs high", stray, 0);

      fin = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule